// File: doc/BRIEF.md
# Card Host Controller Register Slave

This block is the register slave of a storage card host controller. A CPU reaches it over a simple 32-bit bus with read and write strobes. On the card side it presents one command at a time through a valid/ready handshake. It then waits for the card-side engine to report either a completed command, together with up to 128 response bits, or a timeout.

The block also collects an end-of-data pulse and watches two card presence inputs, one for an inserted card and one for a write-protected card. It keeps a write-one-to-clear interrupt status register and an enable register, and drives a single level-sensitive interrupt line. Software loads the argument first, then writes the command word. That write issues the command.

Top module: `card_host_regs`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `cmdValid` is low.
- R2: Offsets 0x04 (enable, 4 bits), 0x08 (buffer base, 32 bits) and 0x10 (argument, 32 bits) read back what was written. Block length (0x24) and block count (0x28) keep only their low 11 bits, which hold the real value minus one.
- R3: A write to 0x0C, when no command is in flight, raises `cmdValid` in the following cycle. The command word is decoded as follows: bits 5:0 give the opcode, bit 6 open-drain mode, bits 9:8 the response kind (0 none, 1 short status, 2 long 136-bit, 3 short operating-conditions), bit 11 busy-wait, bits 13:12 the command class (0 broadcast, 1 broadcast with reply, 2 addressed, 3 addressed with data) and bit 15 read direction. `cmdValid` and every command field hold steady until `cmdReady` is seen.
- R4: A write to the command or the argument register is ignored from the issuing write until the command completes or times out.
- R5: When `rspDone` arrives for an issued command, the 128 response bits are captured: bits 31:0 at 0x14, 63:32 at 0x18, 95:64 at 0x1C and 127:96 at 0x20. Status bit 0 (end of command) is then set.
- R6: When `rspTimeout` arrives for an issued command, status bit 3 is set. Status bit 0 is not set and the response words are not updated, even if `rspDone` is high in the same cycle.
- R7: An `dataEnd` pulse sets status bit 1.
- R8: Offset 0x2C reads bit 0 as card inserted and bit 1 as write-protected. Any change on either input sets status bit 2.
- R9: Writing 1 to a status bit (offset 0x00) clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear keeps the bit set.
- R10: `irq` is high exactly when some status bit is set whose enable bit (same position at 0x04) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Bus write strobe |
| busRd | input | 1 | Bus read strobe |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busRd is high |
| cmdValid | output | 1 | Command offered to card side |
| cmdReady | input | 1 | Card side accepts the command |
| cmdOpcode | output | 6 | Command opcode |
| cmdArg | output | 32 | Command argument |
| cmdRespKind | output | 2 | Expected response kind |
| cmdClass | output | 2 | Command class |
| cmdOpenDrain | output | 1 | Open-drain bus mode |
| cmdBusyWait | output | 1 | Wait for busy release after the response |
| cmdReadDir | output | 1 | Data flows card to host |
| rspDone | input | 1 | Command finished, response valid |
| rspTimeout | input | 1 | Command timed out |
| rspData | input | 128 | Response bits |
| dataEnd | input | 1 | End-of-data pulse |
| cardIn | input | 1 | Card inserted |
| cardWp | input | 1 | Card write-protected |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land on the same clock edge. One pair is a software write-one-to-clear of a status bit and the hardware event that sets that bit. The bench drives a status write of the end-of-data bit in the same cycle as a `dataEnd` pulse, and expects the bit to read back as still set. The other pair is `rspDone` and `rspTimeout` asserted together. The bench expects only the timeout bit to be set and the previously captured response words to be left unchanged.

// File: rtl/card_host_pkg.sv
package card_host_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] A_ENABLE = 8'h04;
  localparam logic [ADDR_W-1:0] A_BUF    = 8'h08;
  localparam logic [ADDR_W-1:0] A_CMD    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_ARG    = 8'h10;
  localparam logic [ADDR_W-1:0] A_RESP0  = 8'h14;
  localparam logic [ADDR_W-1:0] A_BLKLEN = 8'h24;
  localparam logic [ADDR_W-1:0] A_BLKCNT = 8'h28;
  localparam logic [ADDR_W-1:0] A_CARD   = 8'h2C;

  localparam int STAT_W      = 4;
  localparam int ST_CMD_END  = 0;
  localparam int ST_DATA_END = 1;
  localparam int ST_CARD_CHG = 2;
  localparam int ST_TIMEOUT  = 3;

  localparam int OPC_W     = 6;
  localparam int CMD_W     = 16;
  localparam int OD_BIT    = 6;
  localparam int KIND_LSB  = 8;
  localparam int BUSY_BIT  = 11;
  localparam int CLASS_LSB = 12;
  localparam int RD_BIT    = 15;
  localparam logic [CMD_W-1:0] CMD_KEEP = 16'hBB7F;

  typedef enum logic [1:0] {CS_IDLE, CS_ISSUE, CS_WAIT} cmdState_e;

  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrBuf;
    logic wrCmd;
    logic wrArg;
    logic wrBlkLen;
    logic wrBlkCnt;
    logic capResp;
    logic setCmdEnd;
    logic setTimeout;
  } strobe_t;
endpackage

// File: rtl/card_host_ctrl.sv
module card_host_ctrl
  import card_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              cmdReady,
  input  logic              rspDone,
  input  logic              rspTimeout,
  output strobe_t           strobe,
  output logic              cmdValid
);
  cmdState_e stateQ, stateD;
  logic idle, waiting;

  assign idle    = (stateQ == CS_IDLE);
  assign waiting = (stateQ == CS_WAIT);

  always_comb begin
    strobe            = '0;
    strobe.wrStatus   = busWr && busAddr == A_STATUS;
    strobe.wrEnable   = busWr && busAddr == A_ENABLE;
    strobe.wrBuf      = busWr && busAddr == A_BUF;
    strobe.wrCmd      = busWr && busAddr == A_CMD && idle;
    strobe.wrArg      = busWr && busAddr == A_ARG && idle;
    strobe.wrBlkLen   = busWr && busAddr == A_BLKLEN;
    strobe.wrBlkCnt   = busWr && busAddr == A_BLKCNT;
    strobe.setTimeout = waiting && rspTimeout;
    strobe.setCmdEnd  = waiting && rspDone && !rspTimeout;
    strobe.capResp    = waiting && rspDone && !rspTimeout;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      CS_IDLE:  if (strobe.wrCmd) stateD = CS_ISSUE;
      CS_ISSUE: if (cmdReady) stateD = CS_WAIT;
      CS_WAIT:  if (rspDone || rspTimeout) stateD = CS_IDLE;
      default:  stateD = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= CS_IDLE;
    else       stateQ <= stateD;
  end

  assign cmdValid = (stateQ == CS_ISSUE);
endmodule

// File: rtl/card_host_dpath.sv
module card_host_dpath
  import card_host_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 11,
  parameter int RESP_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [RESP_W-1:0] rspData,
  input  logic              dataEnd,
  input  logic              cardIn,
  input  logic              cardWp,
  output logic [OPC_W-1:0]  cmdOpcode,
  output logic [DATA_W-1:0] cmdArg,
  output logic [1:0]        cmdRespKind,
  output logic [1:0]        cmdClass,
  output logic              cmdOpenDrain,
  output logic              cmdBusyWait,
  output logic              cmdReadDir,
  output logic [STAT_W-1:0] statusVec,
  output logic [STAT_W-1:0] enableVec
);
  localparam int RESP_WORDS = RESP_W / DATA_W;

  logic [STAT_W-1:0] statusQ, enableQ, setVec, clrVec;
  logic [DATA_W-1:0] bufQ, argQ;
  logic [CMD_W-1:0]  cmdQ;
  logic [BLK_W-1:0]  blkLenQ, blkCntQ;
  logic [1:0]        cardQ, cardNow;
  logic [DATA_W-1:0] respQ [RESP_WORDS];
  logic [DATA_W-1:0] rdWord;

  assign cardNow = {cardWp, cardIn};

  always_comb begin
    setVec              = '0;
    setVec[ST_CMD_END]  = strobe.setCmdEnd;
    setVec[ST_DATA_END] = dataEnd;
    setVec[ST_CARD_CHG] = (cardNow != cardQ);
    setVec[ST_TIMEOUT]  = strobe.setTimeout;
    clrVec = strobe.wrStatus ? busWdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      bufQ    <= '0;
      argQ    <= '0;
      cmdQ    <= '0;
      blkLenQ <= '0;
      blkCntQ <= '0;
      cardQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~clrVec) | setVec;
      cardQ   <= cardNow;
      if (strobe.wrEnable) enableQ <= busWdata[STAT_W-1:0];
      if (strobe.wrBuf)    bufQ    <= busWdata;
      if (strobe.wrArg)    argQ    <= busWdata;
      if (strobe.wrCmd)    cmdQ    <= busWdata[CMD_W-1:0] & CMD_KEEP;
      if (strobe.wrBlkLen) blkLenQ <= busWdata[BLK_W-1:0];
      if (strobe.wrBlkCnt) blkCntQ <= busWdata[BLK_W-1:0];
    end
  end

  for (genvar w = 0; w < RESP_WORDS; w++) begin : g_resp
    always_ff @(posedge clk) begin
      if (!rstN)               respQ[w] <= '0;
      else if (strobe.capResp) respQ[w] <= rspData[w*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    rdWord = '0;
    if (busRd) begin
      case (busAddr)
        A_STATUS: rdWord = DATA_W'(statusQ);
        A_ENABLE: rdWord = DATA_W'(enableQ);
        A_BUF:    rdWord = bufQ;
        A_CMD:    rdWord = DATA_W'(cmdQ);
        A_ARG:    rdWord = argQ;
        A_BLKLEN: rdWord = DATA_W'(blkLenQ);
        A_BLKCNT: rdWord = DATA_W'(blkCntQ);
        A_CARD:   rdWord = DATA_W'(cardQ);
        default:  rdWord = '0;
      endcase
      for (int i = 0; i < RESP_WORDS; i++)
        if (busAddr == A_RESP0 + ADDR_W'(4 * i)) rdWord = respQ[i];
    end
  end

  assign busRdata     = rdWord;
  assign cmdOpcode    = cmdQ[OPC_W-1:0];
  assign cmdOpenDrain = cmdQ[OD_BIT];
  assign cmdRespKind  = cmdQ[KIND_LSB +: 2];
  assign cmdBusyWait  = cmdQ[BUSY_BIT];
  assign cmdClass     = cmdQ[CLASS_LSB +: 2];
  assign cmdReadDir   = cmdQ[RD_BIT];
  assign cmdArg       = argQ;
  assign statusVec    = statusQ;
  assign enableVec    = enableQ;
endmodule

// File: rtl/card_host_regs.sv
module card_host_regs
  import card_host_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 11,
  parameter int RESP_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [OPC_W-1:0]  cmdOpcode,
  output logic [DATA_W-1:0] cmdArg,
  output logic [1:0]        cmdRespKind,
  output logic [1:0]        cmdClass,
  output logic              cmdOpenDrain,
  output logic              cmdBusyWait,
  output logic              cmdReadDir,
  input  logic              rspDone,
  input  logic              rspTimeout,
  input  logic [RESP_W-1:0] rspData,
  input  logic              dataEnd,
  input  logic              cardIn,
  input  logic              cardWp,
  output logic              irq
);
  strobe_t           strobe;
  logic [STAT_W-1:0] statusVec, enableVec;

  card_host_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .cmdReady(cmdReady), .rspDone(rspDone), .rspTimeout(rspTimeout),
    .strobe(strobe), .cmdValid(cmdValid)
  );

  card_host_dpath #(.DATA_W(DATA_W), .BLK_W(BLK_W), .RESP_W(RESP_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rspData(rspData), .dataEnd(dataEnd), .cardIn(cardIn), .cardWp(cardWp),
    .cmdOpcode(cmdOpcode), .cmdArg(cmdArg), .cmdRespKind(cmdRespKind),
    .cmdClass(cmdClass), .cmdOpenDrain(cmdOpenDrain),
    .cmdBusyWait(cmdBusyWait), .cmdReadDir(cmdReadDir),
    .statusVec(statusVec), .enableVec(enableVec)
  );

  assign irq = |(statusVec & enableVec);
endmodule

// File: rtl/card_host_regs_chk.sv
module card_host_regs_chk
  import card_host_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [OPC_W-1:0]  cmdOpcode,
  input logic [31:0]       cmdArg,
  input logic [1:0]        cmdRespKind,
  input logic [1:0]        cmdClass,
  input logic              rspTimeout,
  input logic              dataEnd,
  input logic              cardIn,
  input logic              cardWp,
  input logic              irq,
  input logic [STAT_W-1:0] statusVec
);
  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOpcode) && $stable(cmdArg)
      && $stable(cmdRespKind) && $stable(cmdClass));

  // R4: an argument write cannot disturb a command already offered
  p_arg_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && $past(cmdValid) |-> $stable(cmdArg));

  p_timeout_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[ST_CMD_END]) |-> !$past(rspTimeout));

  p_data_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataEnd |=> statusVec[ST_DATA_END]);

  p_card_chg_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({cardWp, cardIn}) |=> statusVec[ST_CARD_CHG]);

  p_w1c_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusVec[ST_CMD_END]) |-> $past(busWr && busAddr == A_STATUS && busWdata[ST_CMD_END]));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statusVec != '0);
endmodule

bind card_host_regs card_host_regs_chk i_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOpcode(cmdOpcode), .cmdArg(cmdArg),
  .cmdRespKind(cmdRespKind), .cmdClass(cmdClass), .rspTimeout(rspTimeout),
  .dataEnd(dataEnd), .cardIn(cardIn), .cardWp(cardWp), .irq(irq),
  .statusVec(statusVec)
);

// File: tb/test_card_host_regs.sv
module test_card_host_regs;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rstN = 0;
  logic         busWr = 0, busRd = 0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0, busRdata;
  logic         cmdValid, cmdReady = 0;
  logic [5:0]   cmdOpcode;
  logic [31:0]  cmdArg;
  logic [1:0]   cmdRespKind, cmdClass;
  logic         cmdOpenDrain, cmdBusyWait, cmdReadDir;
  logic         rspDone = 0, rspTimeout = 0;
  logic [127:0] rspData = '0;
  logic         dataEnd = 0, cardIn = 0, cardWp = 0;
  logic         irq;

  int checks = 0, errors = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rdItem_t;
  rdItem_t sbQ[$];
  rdItem_t item;

  card_host_regs i_card_host_regs (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value and compares against the bus
  always @(negedge clk) begin
    if (busRd) begin
      if (sbQ.size() == 0) chk("scoreboard empty", busRdata, 32'hx);
      else begin
        item = sbQ.pop_front();
        chk(item.tag, busRdata, item.exp);
      end
    end
  end

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 0;
  endtask

  task automatic busRead(logic [7:0] a, logic [31:0] e, string tag);
    rdItem_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk); #1;
    busRd = 1; busAddr = a;
    @(posedge clk); #1;
    busRd = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #1; sig = 1;
    @(posedge clk); #1; sig = 0;
  endtask

  task automatic atNeg(string tag, logic [31:0] act, logic [31:0] exp);
    @(negedge clk);
    chk(tag, act, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    atNeg("R1 irq", {31'b0, irq}, 0);
    atNeg("R1 cmdValid", {31'b0, cmdValid}, 0);
    busRead(8'h00, 0, "R1 status");
    busRead(8'h04, 0, "R1 enable");
    busRead(8'h0C, 0, "R1 command");
    busRead(8'h24, 0, "R1 block length");

    // R2 plain registers
    busWrite(8'h04, 32'hF);
    busWrite(8'h08, 32'hDEADBEEF);
    busWrite(8'h10, 32'h12345678);
    busWrite(8'h24, 32'hFFFFFFFF);
    busWrite(8'h28, 32'h00000800);
    busRead(8'h04, 32'hF, "R2 enable");
    busRead(8'h08, 32'hDEADBEEF, "R2 buffer base");
    busRead(8'h10, 32'h12345678, "R2 argument");
    busRead(8'h24, 32'h7FF, "R2 block length 11 bits");
    busRead(8'h28, 32'h000, "R2 block count 11 bits");

    // R3 command issue and field decode
    busWrite(8'h0C, 32'h0000B951);
    atNeg("R3 valid", {31'b0, cmdValid}, 1);
    chk("R3 opcode", {26'b0, cmdOpcode}, 32'h11);
    chk("R3 arg", cmdArg, 32'h12345678);
    chk("R3 kind", {30'b0, cmdRespKind}, 1);
    chk("R3 class", {30'b0, cmdClass}, 3);
    chk("R3 flags", {29'b0, cmdOpenDrain, cmdBusyWait, cmdReadDir}, 3'b111);
    repeat (3) @(posedge clk);
    atNeg("R3 valid held", {31'b0, cmdValid}, 1);

    // R4 writes while busy are dropped
    busWrite(8'h0C, 32'h00000002);
    busWrite(8'h10, 32'h0000AAAA);
    busRead(8'h0C, 32'h0000B951, "R4 command kept");
    busRead(8'h10, 32'h12345678, "R4 argument kept");
    atNeg("R4 opcode kept", {26'b0, cmdOpcode}, 32'h11);

    pulse(cmdReady);
    atNeg("R3 valid drops after ready", {31'b0, cmdValid}, 0);

    // R5 response capture
    rspData = 128'h44444444_33333333_22222222_11111111;
    pulse(rspDone);
    busRead(8'h14, 32'h11111111, "R5 resp word0");
    busRead(8'h18, 32'h22222222, "R5 resp word1");
    busRead(8'h1C, 32'h33333333, "R5 resp word2");
    busRead(8'h20, 32'h44444444, "R5 resp word3");
    busRead(8'h00, 32'h1, "R5 end of command");
    atNeg("R10 irq on", {31'b0, irq}, 1);

    // R9 write-one-to-clear
    busWrite(8'h00, 32'h0);
    busRead(8'h00, 32'h1, "R9 zero write keeps");
    busWrite(8'h00, 32'h1);
    busRead(8'h00, 32'h0, "R9 one write clears");
    atNeg("R10 irq off", {31'b0, irq}, 0);

    // R6 timeout overrides end of command
    busWrite(8'h0C, 32'h00000005);
    pulse(cmdReady);
    rspData = '1;
    @(posedge clk); #1; rspDone = 1; rspTimeout = 1;
    @(posedge clk); #1; rspDone = 0; rspTimeout = 0;
    busRead(8'h00, 32'h8, "R6 timeout only");
    busRead(8'h14, 32'h11111111, "R6 response not captured");
    busWrite(8'h00, 32'h8);

    // R7 end of data, R9 set wins over simultaneous clear
    pulse(dataEnd);
    busRead(8'h00, 32'h2, "R7 end of data");
    @(posedge clk); #1;
    busWr = 1; busAddr = 8'h00; busWdata = 32'h2; dataEnd = 1;
    @(posedge clk); #1;
    busWr = 0; dataEnd = 0;
    busRead(8'h00, 32'h2, "R9 event beats clear");
    busWrite(8'h00, 32'h2);
    busRead(8'h00, 32'h0, "R9 cleared afterwards");

    // R8 card state
    @(posedge clk); #1 cardIn = 1;
    repeat (2) @(posedge clk);
    busRead(8'h2C, 32'h1, "R8 inserted");
    busRead(8'h00, 32'h4, "R8 change on insert");
    busWrite(8'h00, 32'h4);
    @(posedge clk); #1 cardWp = 1;
    repeat (2) @(posedge clk);
    busRead(8'h2C, 32'h3, "R8 write protect");
    busRead(8'h00, 32'h4, "R8 change on protect");

    // R10 enable gating
    busWrite(8'h04, 32'h4);
    atNeg("R10 enabled source", {31'b0, irq}, 1);
    busWrite(8'h04, 32'h1);
    atNeg("R10 masked source", {31'b0, irq}, 0);
    busRead(8'h00, 32'h4, "R10 status still set");

    repeat (2) @(posedge clk);
    chk("scoreboard drained", sbQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule